// File: doc/BRIEF.md
# Pin Sense Detect Latch Unit

This block turns per-pin level-sense settings into a port-wide detect indication that can serve as a wake-up or interrupt source. Each pin has an enable bit and a polarity bit. Enabled pins that sit at their chosen level form a live match vector. A sticky copy of that vector is kept. Software can read the sticky copy and clear bits in it by writing ones.

Two independent detect channels exist: a secure one and a non-secure one. Each has its own mode bit, which picks either the live match vector or the sticky copy as the channel's source. Each channel also produces a one-cycle event pulse whenever its detect output rises. When software clears sticky bits but some remain set while the channel uses the sticky source, the channel drops its output for a fixed number of cycles and then raises it again. This gives the event logic downstream a fresh edge.

All outputs are registered. A change on the inputs, a sticky-vector write or a mode write is visible on the outputs in the cycle after the clock edge that captures it.

Top module: `pin_sense_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `latch_q`, both detect outputs and both event outputs are 0, and both mode bits are 0 (live source).
- R2: Pin i matches when `sense_en[i]` is 1 and `pin_in[i]` differs from `sense_low[i]`. `sense_low[i]`=0 senses a high level and `sense_low[i]`=1 senses a low level. A pin with `sense_en[i]`=0 never matches.
- R3: A channel whose mode bit is 0 drives its detect output to the OR of the match vector, one clock edge after the inputs are presented.
- R4: A sticky bit is set one edge after its pin matches and stays set after the match goes away.
- R5: A sticky write (`latch_wr`=1) clears every sticky bit whose `latch_wdata` bit is 1 and leaves the bits written as 0 unchanged.
- R6: A sticky write cannot clear a bit whose pin matches in the same cycle; that bit reads back 1.
- R7: A channel whose mode bit is 1 drives its detect output to the OR of the sticky vector.
- R8: An event output is high for exactly the single cycle in which its detect output goes from 0 to 1.
- R9: A mode write (`mode_*_wr`=1) takes effect at the next edge, and the detect output re-evaluates with the new source in the same step.
- R10: A sticky write counts as qualifying when three things hold: `latch_wdata` is nonzero, the resulting sticky vector is nonzero, and the channel's mode is 1. After a qualifying write, that channel's detect output is 0 for exactly HOLD_CYCLES cycles and then returns to 1 together with an event.
- R11: A sticky write that is not qualifying (zero data, sticky vector emptied, or mode 0) causes no forced-low window.
- R12: The two channels are independent. A mode value or forced-low window on one channel does not change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Current pin levels |
| sense_en | input | NUM_PINS | Per-pin sense enable |
| sense_low | input | NUM_PINS | Per-pin polarity, 1 = sense low level |
| latch_wr | input | 1 | Sticky-vector clear strobe |
| latch_wdata | input | NUM_PINS | Write-one-to-clear mask |
| latch_q | output | NUM_PINS | Sticky match vector |
| mode_ns_wr | input | 1 | Non-secure mode write strobe |
| mode_ns_val | input | 1 | Non-secure mode value, 1 = sticky source |
| mode_sec_wr | input | 1 | Secure mode write strobe |
| mode_sec_val | input | 1 | Secure mode value, 1 = sticky source |
| detect_ns | output | 1 | Non-secure detect output |
| detect_sec | output | 1 | Secure detect output |
| event_ns | output | 1 | Non-secure rising-edge pulse |
| event_sec | output | 1 | Secure rising-edge pulse |

## Verification
The bench builds the block with NUM_PINS=4 and HOLD_CYCLES=2. With these values, every combination of pin level, enable and polarity can be swept (4096 patterns), so each match rule and each OR reduction is exercised exhaustively. The small forced-low window allows its length to be checked cycle by cycle. Directed sequences on top of the sweep cover sticky clears, clears that do not take, mode switching, and the qualifying and non-qualifying write cases on each channel.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_NS  = 0;
  localparam int CH_SEC = 1;
endpackage

// File: rtl/psd_sense_eval.sv
module psd_sense_eval #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] sense_low,
  output logic [NUM_PINS-1:0] match_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign match_o[i] = sense_en[i] & (pin_in[i] ^ sense_low[i]);
  end
endmodule

// File: rtl/psd_latch.sv
module psd_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] match_i,
  input  logic                clr_en,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] latch_d,
  output logic [NUM_PINS-1:0] latch_q
);
  logic [NUM_PINS-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en ? clr_mask : '0;
    latch_d = (latch_q & ~clr_eff) | match_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/psd_detect_chan.sv
module psd_detect_chan #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_we,
  input  logic mode_wval,
  input  logic live_any,
  input  logic sticky_next_any,
  input  logic clr_req,
  output logic mode_q,
  output logic det_q,
  output logic evt_q
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          mode_d, det_d, evt_d, qualify;

  always_comb begin
    mode_d  = mode_we ? mode_wval : mode_q;
    qualify = clr_req & sticky_next_any & mode_d;
    if (qualify)             hold_d = HW'(HOLD_CYCLES);
    else if (hold_q != '0)   hold_d = hold_q - HW'(1);
    else                     hold_d = '0;
    det_d = (hold_d == '0) & (mode_d ? sticky_next_any : live_any);
    evt_d = det_d & ~det_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      hold_q <= '0;
      det_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
      det_q  <= det_d;
      evt_q  <= evt_d;
    end
  end
endmodule

// File: rtl/pin_sense_detect.sv
module pin_sense_detect
  import psd_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int HOLD_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] sense_low,
  input  logic                latch_wr,
  input  logic [NUM_PINS-1:0] latch_wdata,
  output logic [NUM_PINS-1:0] latch_q,
  input  logic                mode_ns_wr,
  input  logic                mode_ns_val,
  input  logic                mode_sec_wr,
  input  logic                mode_sec_val,
  output logic                detect_ns,
  output logic                detect_sec,
  output logic                event_ns,
  output logic                event_sec
);
  logic [NUM_PINS-1:0] match_vec, latch_next;
  logic [NUM_CH-1:0]   mode_we, mode_wval, mode_q, det, evt;
  logic                clr_req;

  assign clr_req              = latch_wr & (|latch_wdata);
  assign mode_we[CH_NS]       = mode_ns_wr;
  assign mode_wval[CH_NS]     = mode_ns_val;
  assign mode_we[CH_SEC]      = mode_sec_wr;
  assign mode_wval[CH_SEC]    = mode_sec_val;

  psd_sense_eval #(.NUM_PINS(NUM_PINS)) u_eval (
    .pin_in(pin_in), .sense_en(sense_en), .sense_low(sense_low), .match_o(match_vec)
  );

  psd_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .match_i(match_vec), .clr_en(latch_wr),
    .clr_mask(latch_wdata), .latch_d(latch_next), .latch_q(latch_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    psd_detect_chan #(.HOLD_CYCLES(HOLD_CYCLES)) u_chan (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we[c]), .mode_wval(mode_wval[c]),
      .live_any(|match_vec), .sticky_next_any(|latch_next), .clr_req(clr_req),
      .mode_q(mode_q[c]), .det_q(det[c]), .evt_q(evt[c])
    );
  end

  assign detect_ns  = det[CH_NS];
  assign detect_sec = det[CH_SEC];
  assign event_ns   = evt[CH_NS];
  assign event_sec  = evt[CH_SEC];
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] sense_en,
  input logic [NUM_PINS-1:0] sense_low,
  input logic                latch_wr,
  input logic [NUM_PINS-1:0] latch_wdata,
  input logic [NUM_PINS-1:0] latch_q,
  input logic                mode_ns,
  input logic                detect_ns,
  input logic                detect_sec,
  input logic                event_ns,
  input logic                event_sec
);
  p_event_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    event_ns |-> (detect_ns && !$past(detect_ns)));
  p_event_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_sec && !$past(detect_sec)) |-> event_sec);
  p_sticky_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_wr) |-> ((latch_q & $past(latch_q)) == $past(latch_q)));
  p_active_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pin_in) ^ $past(sense_low)) & $past(sense_en) & ~latch_q) == '0));
  p_det_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    detect_sec |-> (latch_q != '0 || (($past(pin_in) ^ $past(sense_low)) & $past(sense_en)) != '0));
  p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch_wr) && $past(latch_wdata) != '0 && latch_q != '0 && mode_ns) |-> !detect_ns);
endmodule

bind pin_sense_detect psd_checker #(.NUM_PINS(NUM_PINS)) u_psd_checker (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_en(sense_en), .sense_low(sense_low),
  .latch_wr(latch_wr), .latch_wdata(latch_wdata), .latch_q(latch_q), .mode_ns(mode_q[0]),
  .detect_ns(detect_ns), .detect_sec(detect_sec), .event_ns(event_ns), .event_sec(event_sec)
);

// File: tb/pin_sense_detect_bench.sv
module pin_sense_detect_bench;
  localparam int N = 4;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] pin_in, sense_en, sense_low, latch_wdata, latch_q;
  logic latch_wr, mode_ns_wr, mode_ns_val, mode_sec_wr, mode_sec_val;
  logic detect_ns, detect_sec, event_ns, event_sec;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_latch;
  logic prev_det;

  always #10 clk = ~clk;

  pin_sense_detect #(.NUM_PINS(N), .HOLD_CYCLES(HOLD)) u_pin_sense_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_en(sense_en), .sense_low(sense_low),
    .latch_wr(latch_wr), .latch_wdata(latch_wdata), .latch_q(latch_q),
    .mode_ns_wr(mode_ns_wr), .mode_ns_val(mode_ns_val),
    .mode_sec_wr(mode_sec_wr), .mode_sec_val(mode_sec_val),
    .detect_ns(detect_ns), .detect_sec(detect_sec),
    .event_ns(event_ns), .event_sec(event_sec)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] match_of(input logic [N-1:0] p, input logic [N-1:0] e,
                                            input logic [N-1:0] l);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = e[i] && (p[i] != l[i]);
    return r;
  endfunction

  // advance one edge; bench model of the sticky vector per R4, R5, R6
  task automatic step();
    exp_latch = (exp_latch & ~(latch_wr ? latch_wdata : '0)) | match_of(pin_in, sense_en, sense_low);
    @(posedge clk);
    @(negedge clk);
    latch_wr = 1'b0;
    mode_ns_wr = 1'b0;
    mode_sec_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pin_in = '0; sense_en = '0; sense_low = '0; latch_wdata = '0;
    latch_wr = 1'b0; mode_ns_wr = 1'b0; mode_ns_val = 1'b0;
    mode_sec_wr = 1'b0; mode_sec_val = 1'b0;
    exp_latch = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 latch", latch_q, '0);
    chk("R1 det", {detect_ns, detect_sec, event_ns, event_sec}, '0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", {detect_ns, detect_sec, event_ns, event_sec}, '0);

    // R2/R3/R4/R8 exhaustive sweep, both channels in live mode
    prev_det = 1'b0;
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] vv;
      logic exp_det;
      vv = 12'(v);
      pin_in = vv[3:0]; sense_en = vv[7:4]; sense_low = vv[11:8];
      exp_det = |match_of(pin_in, sense_en, sense_low);
      step();
      chk("R2 R3 detect_ns", N'(detect_ns), N'(exp_det));
      chk("R12 detect_sec", N'(detect_sec), N'(exp_det));
      chk("R8 event_ns", N'(event_ns), N'(exp_det && !prev_det));
      chk("R4 sticky", latch_q, exp_latch);
      prev_det = exp_det;
    end

    // R5 partial clear with sense off
    sense_en = '0;
    latch_wr = 1'b1; latch_wdata = 4'b0101;
    step();
    chk("R5 partial clear", latch_q, 4'b1010);
    latch_wr = 1'b1; latch_wdata = 4'b1010;
    step();
    chk("R5 full clear", latch_q, 4'b0000);

    // R4 sticky after match goes away; pin0 senses high, pin1 senses low
    sense_en = 4'b0011; sense_low = 4'b0010; pin_in = 4'b0010;
    step();
    chk("R2 no match either polarity", latch_q, 4'b0000);
    pin_in = 4'b0001;
    step();
    chk("R2 both match", latch_q, 4'b0011);
    chk("R3 live det", N'(detect_ns), N'(1));
    pin_in = 4'b0010;
    step();
    chk("R4 sticky kept", latch_q, 4'b0011);
    chk("R3 live det falls", N'(detect_ns), N'(0));

    // R6 clear of active bit does not take
    pin_in = 4'b0011; // pin0 matches, pin1 does not
    latch_wr = 1'b1; latch_wdata = 4'b0011;
    step();
    chk("R6 active bit kept", latch_q, 4'b0001);
    chk("R11 mode0 no hold", N'(detect_ns), N'(1));

    // R7/R9 switch ns to sticky source while match inactive
    pin_in = 4'b0010;
    step();
    chk("R3 live low", N'(detect_ns), N'(0));
    mode_ns_wr = 1'b1; mode_ns_val = 1'b1;
    step();
    chk("R7 R9 sticky source", N'(detect_ns), N'(1));
    chk("R8 event on mode switch", N'(event_ns), N'(1));
    chk("R12 sec stays live", N'(detect_sec), N'(0));
    step();
    chk("R8 single cycle", N'(event_ns), N'(0));

    // R10 qualifying write: pin0 still active so bit survives
    pin_in = 4'b0011;
    step();
    latch_wr = 1'b1; latch_wdata = 4'b0001;
    step();
    chk("R10 low cycle1", N'(detect_ns), N'(0));
    chk("R6 bit survives", latch_q, 4'b0001);
    chk("R12 sec unaffected", N'(detect_sec), N'(1));
    step();
    chk("R10 low cycle2", N'(detect_ns), N'(0));
    chk("R12 sec unaffected 2", N'(detect_sec), N'(1));
    step();
    chk("R10 reraised", N'(detect_ns), N'(1));
    chk("R10 event", N'(event_ns), N'(1));
    chk("R12 no sec event", N'(event_sec), N'(0));

    // R11 zero-data write: no window
    latch_wr = 1'b1; latch_wdata = 4'b0000;
    step();
    chk("R11 zero data", N'(detect_ns), N'(1));

    // R11 write that empties sticky vector
    pin_in = 4'b0010;
    latch_wr = 1'b1; latch_wdata = 4'b0001;
    step();
    chk("R11 emptied latch", latch_q, 4'b0000);
    chk("R11 emptied det", N'(detect_ns), N'(0));
    pin_in = 4'b0011;
    step();
    chk("R7 sticky rises", N'(detect_ns), N'(1));
    chk("R8 event again", N'(event_ns), N'(1));

    // R9/R12 back to live on ns, sticky on sec
    pin_in = 4'b0010;
    mode_ns_wr = 1'b1; mode_ns_val = 1'b0;
    mode_sec_wr = 1'b1; mode_sec_val = 1'b1;
    step();
    chk("R9 ns live now", N'(detect_ns), N'(0));
    chk("R9 sec sticky now", N'(detect_sec), N'(1));
    chk("R4 sticky value", latch_q, 4'b0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule